// File: doc/BRIEF.md
# Audio Ring-Buffer DMA Pointer Controller

This block keeps the pointer state for a pair of audio DMA channels, one capturing samples from the codec into memory and one playing samples from memory to the codec. Each channel walks a ring buffer whose position is counted in whole 32-byte chunks. One pointer belongs to hardware and the other to software, and the direction of the channel decides which is which. A chunk-transfer strobe from the memory side moves the hardware pointer forward. When that pointer would overrun the software pointer, or has nothing left to read, the step is refused and an error flag is raised.

Each channel can also raise a section interrupt. The comparison uses a power-of-two mask and splits the ring into equal slices. The four event flags share a sticky status register that is cleared by writing ones, and a mask register selects which flags reach the interrupt line. A small sample path flips the sign bit of every byte in 8-bit mode. On playback it outputs silence while the channel is idle and repeats the last sample when the channel underflows.

Top module: `audio_ring_dma`

## Requirements
- R1: After reset both control words, the status register, the mask register, `irq`, `xfer_acc` and `play_sample` are all zero.
- R2: A control write without bit 31 loads the ring size (bits 30:28), the enable (bit 27), the trigger mask code (bits 26:24) and the trigger pointer (bits 23:16). The software pointer is taken from the read-pointer field (bits 15:8) on the capture channel and from the write-pointer field (bits 7:0) on the playback channel. The hardware pointer field of the written word is ignored, and a channel that was disabled starts with its hardware pointer at zero.
- R3: Each accepted transfer request moves the hardware pointer forward one chunk, wrapping at 2^(size+1) chunks. A request is ignored while the channel is disabled, and also in a cycle where the same channel's control word is written.
- R4: On capture, a request that would move the write pointer onto the read pointer is refused, the pointer keeps its value, and status bit 0 is set.
- R5: On playback, a request made while the read pointer equals the write pointer is refused, the pointer keeps its value, status bit 2 is set, and `play_sample` holds its previous value.
- R6: A control write with the enable bit clear sets both pointers of that channel to zero. A write with bit 31 set clears every field of that channel.
- R7: After an accepted step, a trigger event is raised when the low (8 - code) bits of the new hardware pointer match the same bits of the trigger pointer. Code 0 gives one event per 256 chunks and code 7 gives one every 2 chunks. The event sets status bit 1 for capture and bit 3 for playback.
- R8: Status bits stay set until a write to `irq_clr_wr` with a one in that bit position clears them; a new event in the same cycle wins over the clear. `irq_pend` is the status ANDed with the mask, and `irq` is high when any bit of `irq_pend` is set.
- R9: In 8-bit format (the `fmt_8bit` bit for the channel is 1) every byte of a sample is XORed with 0x80. In 16-bit format samples pass unchanged. Capture conversion is combinational. Playback conversion is registered on each accepted request.
- R10: While the playback channel is disabled, `play_sample` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 2 | Control write strobe; bit 0 capture, bit 1 playback |
| ctl_wdata | input | 32 | Control word to write |
| cap_ctl_rdata | output | 32 | Capture control word readback (bit 31 reads 0) |
| play_ctl_rdata | output | 32 | Playback control word readback (bit 31 reads 0) |
| xfer_req | input | 2 | Chunk-transfer strobe per channel |
| xfer_acc | output | 2 | Request accepted this cycle, per channel |
| fmt_8bit | input | 2 | 1 selects 8-bit unsigned format, per channel |
| cap_codec_data | input | 16 | Sample arriving from the codec |
| cap_mem_data | output | 16 | Converted sample toward memory |
| play_mem_data | input | 16 | Sample read from memory |
| play_sample | output | 16 | Converted sample toward the codec |
| irq_clr_wr | input | 1 | Write-one-to-clear strobe for status |
| irq_mask_wr | input | 1 | Mask register write strobe |
| irq_wdata | input | 4 | Data for the clear or mask write |
| irq_status | output | 4 | Sticky event flags |
| irq_mask | output | 4 | Mask register |
| irq_pend | output | 4 | Status ANDed with mask |
| irq | output | 1 | Any pending masked event |

## Verification
If a hardware pointer is stepped wrongly or wraps at the wrong length, the error shows in the control readback in the cycle right after the request. Within a few steps it also moves the cycle in which the overflow or underflow flag rises, because the refusal point depends on the pointer distance. A trigger mask decoded wrongly sets status bits 1 or 3 at the wrong chunk counts, which shows up on the first section boundary of a ring pass. A stale playback sample register shows on `play_sample` as a wrong repeat on the first underflow, or as a non-zero value once the channel is disabled.

// File: rtl/ardma_pkg.sv
package ardma_pkg;
   localparam int CH_CAP  = 0;
   localparam int CH_PLAY = 1;
   localparam int N_CH    = 2;
   // event positions in the shared status register
   localparam int EV_CAP_OVF   = 0;
   localparam int EV_CAP_TRIG  = 1;
   localparam int EV_PLAY_UNF  = 2;
   localparam int EV_PLAY_TRIG = 3;
   localparam int N_EV         = 4;
endpackage

// File: rtl/ardma_ring.sv
module ardma_ring #(
   parameter int SIZE_W = 3,
   parameter bit IS_OUT = 1'b0,
   localparam int PTR_W = 1 << SIZE_W,
   localparam int CTL_W = 3 * PTR_W + 2 * SIZE_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic              wr_rst,
   input  logic [SIZE_W-1:0] wr_size,
   input  logic              wr_en,
   input  logic [SIZE_W-1:0] wr_tm,
   input  logic [PTR_W-1:0]  wr_tp,
   input  logic [PTR_W-1:0]  wr_sw,
   input  logic              xfer_req,
   output logic [CTL_W-1:0]  ctl_rdata,
   output logic              active,
   output logic              xfer_acc,
   output logic              err_pulse,
   output logic              trig_pulse
);
   localparam logic [PTR_W-1:0]  ALL1   = '1;
   localparam logic [SIZE_W-1:0] TOP_SZ = SIZE_W'(PTR_W - 1);

   logic [SIZE_W-1:0] size_q, tm_q;
   logic [PTR_W-1:0]  tp_q, hw_q, sw_q;
   logic              en_q;

   logic [PTR_W-1:0]  ring_mask, wr_mask, sect_mask, hw_nxt, rd_wp, rd_rp;
   logic              blocked, req_live;

   assign ring_mask = ALL1 >> (TOP_SZ - size_q);
   assign wr_mask   = ALL1 >> (TOP_SZ - wr_size);
   assign sect_mask = ALL1 >> tm_q;
   assign hw_nxt    = (hw_q + PTR_W'(1)) & ring_mask;

   if (IS_OUT) begin : g_out
      assign blocked = (hw_q == sw_q);
      assign rd_wp   = sw_q;
      assign rd_rp   = hw_q;
   end else begin : g_in
      assign blocked = (hw_nxt == sw_q);
      assign rd_wp   = hw_q;
      assign rd_rp   = sw_q;
   end

   assign req_live   = xfer_req & en_q & ~ctl_wr;
   assign xfer_acc   = req_live & ~blocked;
   assign err_pulse  = req_live & blocked;
   assign trig_pulse = xfer_acc & ((hw_nxt & sect_mask) == (tp_q & sect_mask));
   assign active     = en_q;
   assign ctl_rdata  = {1'b0, size_q, en_q, tm_q, tp_q, rd_rp, rd_wp};

   always_ff @(posedge clk) begin
      if (!rst_n || (ctl_wr && wr_rst)) begin
         size_q <= '0;
         tm_q   <= '0;
         tp_q   <= '0;
         en_q   <= 1'b0;
         hw_q   <= '0;
         sw_q   <= '0;
      end else if (ctl_wr) begin
         size_q <= wr_size;
         tm_q   <= wr_tm;
         tp_q   <= wr_tp;
         en_q   <= wr_en;
         if (wr_en) begin
            sw_q <= wr_sw & wr_mask;
            hw_q <= en_q ? (hw_q & wr_mask) : '0;
         end else begin
            sw_q <= '0;
            hw_q <= '0;
         end
      end else if (xfer_acc) begin
         hw_q <= hw_nxt;
      end
   end

   // R3: the hardware pointer moves only on an accepted step or a control write
   a_r3_hw_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_wr && !xfer_acc) |=> $stable(hw_q));

   // R6: an idle channel keeps both pointers at zero
   a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> (hw_q == '0 && sw_q == '0));

   if (IS_OUT) begin : g_chk_out
      // R5: a refused playback step leaves both pointers where they were
      a_r5_unf_hold: assert property (@(posedge clk) disable iff (!rst_n)
         err_pulse |=> ($stable(hw_q) && $stable(sw_q)));
   end else begin : g_chk_in
      // R4: an accepted capture step never lands on the software pointer
      a_r4_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
         xfer_acc |=> (hw_q != sw_q));
   end
endmodule

// File: rtl/ardma_irq.sv
module ardma_irq #(
   parameter int N_EV = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_EV-1:0] ev_set,
   input  logic            clr_wr,
   input  logic            mask_wr,
   input  logic [N_EV-1:0] wdata,
   output logic [N_EV-1:0] status,
   output logic [N_EV-1:0] mask,
   output logic [N_EV-1:0] pend,
   output logic            irq
);
   logic [N_EV-1:0] clr_bits;

   assign clr_bits = clr_wr ? wdata : '0;
   assign pend     = status & mask;
   assign irq      = |pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= '0;
         mask   <= '0;
      end else begin
         status <= (status & ~clr_bits) | ev_set;
         if (mask_wr) mask <= wdata;
      end
   end

   // R8: a raised event is visible in status on the next cycle, even under a clear
   a_r8_event_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_set != '0) |=> ((status & $past(ev_set)) == $past(ev_set)));

   // R8: without an event or a clear the status does not move
   a_r8_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_wr && ev_set == '0) |=> $stable(status));
endmodule

// File: rtl/ardma_fmt.sv
module ardma_fmt #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fmt8_cap,
   input  logic              fmt8_play,
   input  logic [DATA_W-1:0] cap_codec,
   output logic [DATA_W-1:0] cap_mem,
   input  logic              play_active,
   input  logic              play_load,
   input  logic [DATA_W-1:0] play_mem,
   output logic [DATA_W-1:0] play_sample
);
   localparam int NB = DATA_W / 8;
   localparam logic [DATA_W-1:0] SIGN_BITS = {NB{8'h80}};

   function automatic logic [DATA_W-1:0] conv(input logic [DATA_W-1:0] d, input logic f8);
      return f8 ? (d ^ SIGN_BITS) : d;
   endfunction

   logic [DATA_W-1:0] out_q;

   assign cap_mem     = conv(cap_codec, fmt8_cap);
   assign play_sample = play_active ? out_q : '0;

   always_ff @(posedge clk) begin
      if (!rst_n || !play_active) out_q <= '0;
      else if (play_load)         out_q <= conv(play_mem, fmt8_play);
   end

   // R5: with no accepted step the sample toward the codec repeats
   a_r5_sample_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (play_active && !play_load) |=> (!play_active || $stable(play_sample)));

   // R10: the cycle the channel goes idle its output is silence
   a_r10_idle_silence: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(play_active) |-> (play_sample == '0));
endmodule

// File: rtl/audio_ring_dma.sv
module audio_ring_dma #(
   parameter int SIZE_W = 3,
   parameter int DATA_W = 16,
   localparam int PTR_W = 1 << SIZE_W,
   localparam int CTL_W = 3 * PTR_W + 2 * SIZE_W + 2,
   localparam int N_EV  = ardma_pkg::N_EV
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   output logic [CTL_W-1:0]  cap_ctl_rdata,
   output logic [CTL_W-1:0]  play_ctl_rdata,
   input  logic [1:0]        xfer_req,
   output logic [1:0]        xfer_acc,
   input  logic [1:0]        fmt_8bit,
   input  logic [DATA_W-1:0] cap_codec_data,
   output logic [DATA_W-1:0] cap_mem_data,
   input  logic [DATA_W-1:0] play_mem_data,
   output logic [DATA_W-1:0] play_sample,
   input  logic              irq_clr_wr,
   input  logic              irq_mask_wr,
   input  logic [N_EV-1:0]   irq_wdata,
   output logic [N_EV-1:0]   irq_status,
   output logic [N_EV-1:0]   irq_mask,
   output logic [N_EV-1:0]   irq_pend,
   output logic              irq
);
   import ardma_pkg::*;

   // control word field positions
   localparam int WP_LO  = 0;
   localparam int RP_LO  = PTR_W;
   localparam int TP_LO  = 2 * PTR_W;
   localparam int TM_LO  = 3 * PTR_W;
   localparam int EN_BIT = TM_LO + SIZE_W;
   localparam int SZ_LO  = EN_BIT + 1;
   localparam int RST_BIT = SZ_LO + SIZE_W;

   if (SIZE_W < 1 || SIZE_W > 4) begin : g_bad_size
      $error("SIZE_W must lie in 1..4");
   end
   if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_bad_data
      $error("DATA_W must be a whole number of bytes");
   end

   logic [CTL_W-1:0] rdata [N_CH];
   logic [N_CH-1:0]  act, err, trg;

   for (genvar g = 0; g < N_CH; g++) begin : g_ch
      localparam int SW_LO = (g == CH_PLAY) ? WP_LO : RP_LO;
      ardma_ring #(.SIZE_W(SIZE_W), .IS_OUT(g == CH_PLAY)) u_ring (
         .clk       (clk),
         .rst_n     (rst_n),
         .ctl_wr    (ctl_wr[g]),
         .wr_rst    (ctl_wdata[RST_BIT]),
         .wr_size   (ctl_wdata[SZ_LO +: SIZE_W]),
         .wr_en     (ctl_wdata[EN_BIT]),
         .wr_tm     (ctl_wdata[TM_LO +: SIZE_W]),
         .wr_tp     (ctl_wdata[TP_LO +: PTR_W]),
         .wr_sw     (ctl_wdata[SW_LO +: PTR_W]),
         .xfer_req  (xfer_req[g]),
         .ctl_rdata (rdata[g]),
         .active    (act[g]),
         .xfer_acc  (xfer_acc[g]),
         .err_pulse (err[g]),
         .trig_pulse(trg[g])
      );
   end

   assign cap_ctl_rdata  = rdata[CH_CAP];
   assign play_ctl_rdata = rdata[CH_PLAY];

   logic [N_EV-1:0] ev;
   always_comb begin
      ev               = '0;
      ev[EV_CAP_OVF]   = err[CH_CAP];
      ev[EV_CAP_TRIG]  = trg[CH_CAP];
      ev[EV_PLAY_UNF]  = err[CH_PLAY];
      ev[EV_PLAY_TRIG] = trg[CH_PLAY];
   end

   ardma_irq #(.N_EV(N_EV)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_set (ev),
      .clr_wr (irq_clr_wr),
      .mask_wr(irq_mask_wr),
      .wdata  (irq_wdata),
      .status (irq_status),
      .mask   (irq_mask),
      .pend   (irq_pend),
      .irq    (irq)
   );

   ardma_fmt #(.DATA_W(DATA_W)) u_fmt (
      .clk        (clk),
      .rst_n      (rst_n),
      .fmt8_cap   (fmt_8bit[CH_CAP]),
      .fmt8_play  (fmt_8bit[CH_PLAY]),
      .cap_codec  (cap_codec_data),
      .cap_mem    (cap_mem_data),
      .play_active(act[CH_PLAY]),
      .play_load  (xfer_acc[CH_PLAY]),
      .play_mem   (play_mem_data),
      .play_sample(play_sample)
   );
endmodule

// File: tb/audio_ring_dma_tb.sv
module audio_ring_dma_tb;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ctl_wr = '0;
   logic [31:0] ctl_wdata = '0;
   logic [31:0] cap_ctl_rdata, play_ctl_rdata;
   logic [1:0]  xfer_req = '0;
   logic [1:0]  xfer_acc;
   logic [1:0]  fmt_8bit = '0;
   logic [15:0] cap_codec_data = '0;
   logic [15:0] cap_mem_data;
   logic [15:0] play_mem_data = '0;
   logic [15:0] play_sample;
   logic        irq_clr_wr = 1'b0;
   logic        irq_mask_wr = 1'b0;
   logic [3:0]  irq_wdata = '0;
   logic [3:0]  irq_status, irq_mask, irq_pend;
   logic        irq;

   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;

   audio_ring_dma u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .cap_ctl_rdata(cap_ctl_rdata), .play_ctl_rdata(play_ctl_rdata),
      .xfer_req(xfer_req), .xfer_acc(xfer_acc), .fmt_8bit(fmt_8bit),
      .cap_codec_data(cap_codec_data), .cap_mem_data(cap_mem_data),
      .play_mem_data(play_mem_data), .play_sample(play_sample),
      .irq_clr_wr(irq_clr_wr), .irq_mask_wr(irq_mask_wr), .irq_wdata(irq_wdata),
      .irq_status(irq_status), .irq_mask(irq_mask), .irq_pend(irq_pend), .irq(irq)
   );

   always #(PERIOD / 2) clk = ~clk;

   function automatic logic [31:0] mk(input int rs, input int sz, input int en,
                                      input int tm, input int tp, input int rp, input int wp);
      return {rs[0], sz[2:0], en[0], tm[2:0], tp[7:0], rp[7:0], wp[7:0]};
   endfunction

   function automatic logic [15:0] flip(input logic [15:0] d, input logic f8);
      return f8 ? (d ^ 16'h8080) : d;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr_ctl(input int ch, input logic [31:0] d);
      ctl_wr[ch] = 1'b1;
      ctl_wdata  = d;
      tick();
      ctl_wr = '0;
   endtask

   task automatic req(input int ch);
      xfer_req[ch] = 1'b1;
      tick();
      xfer_req = '0;
   endtask

   task automatic clr_sts();
      irq_clr_wr = 1'b1;
      irq_wdata  = 4'hF;
      tick();
      irq_clr_wr = 1'b0;
   endtask

   initial begin
      #(PERIOD * 100000);
      if (!done) begin
         nbad++;
         $display("FAIL watchdog: got running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      int len, tp, tm, m, w, r, wp, nxt;
      bit ev, tr;
      logic [15:0] smp;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1: reset state
      chk("R1 cap ctl", cap_ctl_rdata, 32'h0);
      chk("R1 play ctl", play_ctl_rdata, 32'h0);
      chk("R1 status", 32'(irq_status), 32'h0);
      chk("R1 mask", 32'(irq_mask), 32'h0);
      chk("R1 irq", 32'(irq), 32'h0);
      chk("R1 play_sample", 32'(play_sample), 32'h0);
      chk("R1 acc", 32'(xfer_acc), 32'h0);

      // capture sweep over every ring size and trigger mask code
      for (int s = 0; s < 8; s++) begin
         len = 2 << s;
         tm  = s;
         m   = 255 >> tm;
         tp  = (s * 37) & 255;
         wr_ctl(0, mk(0, 0, 0, 0, 0, 0, 0));
         wr_ctl(0, mk(0, s, 1, tm, tp, 0, 0));
         w = 0;
         for (int k = 0; k <= len; k++) begin
            req(0);
            nxt = (w + 1) % len;
            ev  = (nxt == 0);
            tr  = 1'b0;
            if (!ev) begin
               w  = nxt;
               tr = ((nxt & m) == (tp & m));
            end
            chk("R3 cap wptr", 32'(cap_ctl_rdata[7:0]), 32'(w));
            chk("R4 cap overflow", 32'(irq_status[0]), 32'(ev));
            chk("R7 cap trigger", 32'(irq_status[1]), 32'(tr));
            clr_sts();
         end
      end

      // playback sweep with format alternating per step
      for (int s = 0; s < 8; s++) begin
         len = 2 << s;
         tm  = 7 - s;
         m   = 255 >> tm;
         tp  = (s * 53) & 255;
         wp  = (s * 3 + 1) % len;
         wr_ctl(1, mk(0, 0, 0, 0, 0, 0, 0));
         chk("R10 idle silence", 32'(play_sample), 32'h0);
         wr_ctl(1, mk(0, s, 1, tm, tp, 0, wp));
         r   = 0;
         smp = '0;
         chk("R5 start sample", 32'(play_sample), 32'h0);
         for (int k = 0; k < len; k++) begin
            play_mem_data = 16'(k * 4099 + s * 17);
            fmt_8bit[1]   = 1'(k & 1);
            req(1);
            ev = (r == wp);
            tr = 1'b0;
            if (!ev) begin
               r   = (r + 1) % len;
               tr  = ((r & m) == (tp & m));
               smp = flip(16'(k * 4099 + s * 17), 1'(k & 1));
            end
            chk("R3 play rptr", 32'(play_ctl_rdata[15:8]), 32'(r));
            chk("R5 play underflow", 32'(irq_status[2]), 32'(ev));
            chk("R7 play trigger", 32'(irq_status[3]), 32'(tr));
            chk("R9 play sample", 32'(play_sample), 32'(smp));
            clr_sts();
         end
      end

      // R6 / R10: disabling playback zeroes pointers and silences output
      wr_ctl(1, mk(0, 5, 0, 2, 9, 3, 3));
      chk("R6 play ptrs zero", 32'(play_ctl_rdata[15:0]), 32'h0);
      chk("R10 play off", 32'(play_sample), 32'h0);

      // R9: capture conversion
      for (int i = 0; i < 64; i++) begin
         fmt_8bit[0]    = 1'(i & 1);
         cap_codec_data = 16'(i * 1031);
         #1;
         chk("R9 cap convert", 32'(cap_mem_data), 32'(flip(16'(i * 1031), 1'(i & 1))));
         tick();
      end

      // R3: requests while disabled are ignored
      wr_ctl(0, mk(0, 7, 0, 0, 0, 0, 0));
      chk("R6 cap ptrs zero", 32'(cap_ctl_rdata[15:0]), 32'h0);
      req(0);
      chk("R3 disabled wptr", 32'(cap_ctl_rdata[7:0]), 32'h0);
      chk("R3 disabled status", 32'(irq_status), 32'h0);

      // R3: control write wins over a request in the same cycle
      xfer_req[0] = 1'b1;
      wr_ctl(0, mk(0, 7, 1, 0, 0, 8'h10, 0));
      xfer_req = '0;
      chk("R3 collision wptr", 32'(cap_ctl_rdata[7:0]), 32'h0);
      chk("R3 collision status", 32'(irq_status), 32'h0);

      // R2: field loading, hardware pointer field ignored
      wr_ctl(0, mk(0, 0, 0, 0, 0, 0, 0));
      wr_ctl(0, mk(0, 7, 1, 3, 8'h5A, 8'h40, 8'h55));
      chk("R2 cap word", cap_ctl_rdata, mk(0, 7, 1, 3, 8'h5A, 8'h40, 0));

      // R6: reset bit clears everything
      wr_ctl(0, mk(1, 7, 1, 3, 8'h5A, 8'h40, 8'h55));
      chk("R6 reset bit", cap_ctl_rdata, 32'h0);

      // R8: mask, pending, write-one-to-clear, set beats clear
      wr_ctl(0, mk(0, 7, 1, 7, 0, 8'h80, 0));
      irq_mask_wr = 1'b1;
      irq_wdata   = 4'b0010;
      tick();
      irq_mask_wr = 1'b0;
      req(0);
      chk("R8 no event irq", 32'(irq), 32'h0);
      req(0);
      chk("R8 status", 32'(irq_status), 32'h2);
      chk("R8 pend", 32'(irq_pend), 32'h2);
      chk("R8 irq", 32'(irq), 32'h1);
      clr_sts();
      chk("R8 cleared", 32'(irq), 32'h0);
      req(0);
      irq_clr_wr  = 1'b1;
      irq_wdata   = 4'hF;
      xfer_req[0] = 1'b1;
      tick();
      irq_clr_wr = 1'b0;
      xfer_req   = '0;
      chk("R8 set wins", 32'(irq_status), 32'h2);
      irq_mask_wr = 1'b1;
      irq_wdata   = 4'b0000;
      tick();
      irq_mask_wr = 1'b0;
      chk("R8 masked pend", 32'(irq_pend), 32'h0);
      chk("R8 masked irq", 32'(irq), 32'h0);
      chk("R8 status kept", 32'(irq_status), 32'h2);
      clr_sts();
      chk("R8 status clear", 32'(irq_status), 32'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule